// File: doc/BRIEF.md
# SPI Master Controller with Register Port and FIFOs

This block is a host-programmed SPI master. Software reaches it through a small 32-bit register port with three addresses: a control/status word, a data port and a clock divider. Bytes written to the data port enter a 16-entry transmit queue. While software holds the run flag high, the serial engine takes bytes from that queue and shifts each one out most significant bit first. For every byte sent it stores the byte captured from the serial input in a 16-entry receive queue, and software pops that queue by reading the data port.

The serial clock idles at a programmable level. Sampling happens on the first or the second clock edge of each bit, so all four clock modes are covered. Three chip-select lines are provided. The control word picks one of them, or none. Each line can be made active-high on its own, or all of them together with one global bit. An interrupt line combines a "transfer finished" condition with a "receive queue needs reading" condition, each with its own enable.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control/status word (offset 0x0) reads 0x0004_0000, meaning only the transmit-space flag is set. The divider (offset 0x8) reads 0, every chip-select line sits high, and the interrupt output is low.
- R2: Control fields read back from the bit they were written to. These are select bits 1:0, sample-phase bit 2, idle-clock bit 3, global select polarity bit 6, run bit 7, done-interrupt enable bit 9, fill-interrupt enable bit 10, read-enable bit 12 and per-line polarity bits 23:21 for lines 0..2. Queue-flush bits 4 and 5 always read 0. The divider keeps its low 16 bits and reads 0 above them.
- R3: A write to offset 0x4 queues bits 7:0 for transmission. Status bit 18 (transmit space) is 1 while fewer than 16 bytes wait, and 0 at 16. A write to a full transmit queue is dropped.
- R4: Each byte leaves on the data output MSB first, with 8 clock pulses. In every clock mode the bits are sampled on the leading edge when bit 2 is 0 and on the trailing edge when it is 1. The byte sampled from the serial input is pushed to the receive queue.
- R5: The serial clock rests at the level of bit 3 whenever no byte is shifting. Each half period lasts divider/2 system cycles. A divider of 1 acts as 2, and 0 acts as 65536. Clearing the run bit stops a byte in progress within one cycle.
- R6: Line i is active when the run bit is set and the select field equals i. Select value 3 activates none. The active level of line i is high when bit 6 or bit 21+i is set, and low otherwise. An inactive line holds the opposite level.
- R7: Status bit 16 (done) is 1 exactly when the run bit is set, the transmit queue is empty and no byte is shifting. Writing a byte clears it.
- R8: Status bit 17 is 1 when the receive queue holds data. Bit 19 is 1 when it holds 12 or more bytes and clears below 12. Bit 20 is 1 when it holds 16.
- R9: No byte starts while the receive queue is full. Shifting resumes once a byte is read out.
- R10: Writing 1 to bit 4 or bit 5 of the control word empties the transmit or receive queue respectively, in the same write.
- R11: The interrupt output is high when (done and bit 9) or (bit 19 condition and bit 10).
- R12: A read at offset 0x4 returns the oldest received byte in bits 7:0 and removes it. A read of an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset: 0x0 control/status, 0x4 data, 0x8 divider |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines at pin level |

## Verification
The serial input is tied to the inverted serial output, so each received byte must be the complement of the one sent. A bench-side monitor rebuilds the sent byte from the data output on the edge that the selected mode samples on. Running the same byte set through all four clock modes exposes an edge chosen wrongly, a bit order swapped, or a capture off by one bit, because any of these changes either the monitored byte or the complemented receive value. Divider values 1, 4, 6 and 0 separate correct half-period counting from off-by-one counting and from mishandling of the two special divider codes. Filling the queues to 12, 16 and 17 entries separates the level flags and the stall from plain overflow.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W   = 8;
    localparam int REG_W    = 32;
    localparam int DIV_W    = 16;
    localparam int NUM_CS   = 3;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_DATA = 4'h4;
    localparam logic [3:0] OFF_DIV  = 4'h8;

    localparam int B_CPHA    = 2;
    localparam int B_CPOL    = 3;
    localparam int B_FLUSHTX = 4;
    localparam int B_FLUSHRX = 5;
    localparam int B_GPOL    = 6;
    localparam int B_RUN     = 7;
    localparam int B_IEDONE  = 9;
    localparam int B_IEFILL  = 10;
    localparam int B_RDEN    = 12;
    localparam int B_DONE    = 16;
    localparam int B_RXAV    = 17;
    localparam int B_TXSP    = 18;
    localparam int B_RXHI    = 19;
    localparam int B_RXFULL  = 20;
    localparam int B_LPOL    = 21;

    typedef struct packed {
        logic [NUM_CS-1:0] line_pol;
        logic              rd_en;
        logic              ie_fill;
        logic              ie_done;
        logic              run;
        logic              gpol;
        logic              cpol;
        logic              cpha;
        logic [1:0]        sel;
    } ctrl_t;

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

    function automatic logic [NUM_CS-1:0] active_levels(ctrl_t c);
        return c.line_pol | {NUM_CS{c.gpol}};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = empty ? '0 : mem[rp];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= nxt(wp);
            end
            if (do_pop)
                rp <= nxt(rp);
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int BITS   = DATA_W,
    parameter int DIVW   = DIV_W,
    localparam int CNT_W = DIVW + 1,
    localparam int IDX_W = $clog2(2 * BITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            go,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [DIVW-1:0] div,
    input  logic [BITS-1:0] tx_byte,
    output logic            tx_pop,
    input  logic            miso,
    output logic            rx_push,
    output logic [BITS-1:0] rx_byte,
    output logic            busy,
    output logic            sclk,
    output logic            mosi
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(2 * BITS - 1);

    sh_state_e        state;
    logic [CNT_W-1:0] cnt, half;
    logic [IDX_W-1:0] idx;
    logic             phase;
    logic [BITS-1:0]  tx_sh, rx_sh;
    logic             tick, leading, sample_now, shift_now;

    always_comb begin
        if (div == '0)
            half = CNT_W'(1) << (DIVW - 1);
        else if (div[DIVW-1:1] == '0)
            half = CNT_W'(1);
        else
            half = {2'b00, div[DIVW-1:1]};
    end

    assign busy       = (state == SH_RUN);
    assign tick       = busy && (cnt == half - 1'b1);
    assign leading    = !idx[0];
    assign sample_now = tick && (leading != cpha);
    assign shift_now  = tick && (cpha ? (leading && idx != '0) : (!leading && idx != LAST));
    assign tx_pop     = en && go && (state == SH_IDLE);
    assign rx_push    = tick && (idx == LAST);
    assign rx_byte    = cpha ? {rx_sh[BITS-2:0], miso} : rx_sh;
    assign sclk       = cpol ^ phase;
    assign mosi       = tx_sh[BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            cnt   <= '0;
            idx   <= '0;
            phase <= 1'b0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (!en) begin
            state <= SH_IDLE;
            cnt   <= '0;
            phase <= 1'b0;
        end else begin
            case (state)
                SH_IDLE: if (go) begin
                    state <= SH_RUN;
                    tx_sh <= tx_byte;
                    cnt   <= '0;
                    idx   <= '0;
                    phase <= 1'b0;
                end
                SH_RUN: if (tick) begin
                    cnt   <= '0;
                    phase <= !phase;
                    idx   <= idx + 1'b1;
                    if (shift_now)
                        tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                    if (sample_now)
                        rx_sh <= {rx_sh[BITS-2:0], miso};
                    if (idx == LAST)
                        state <= SH_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FILL_LEVEL = 12,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;

    logic wr_ctrl, wr_data, rd_data, wr_div;
    assign wr_ctrl = reg_en && reg_we && (reg_addr == OFF_CTRL);
    assign wr_data = reg_en && reg_we && (reg_addr == OFF_DATA);
    assign rd_data = reg_en && !reg_we && (reg_addr == OFF_DATA);
    assign wr_div  = reg_en && reg_we && (reg_addr == OFF_DIV);

    logic flush_tx, flush_rx;
    assign flush_tx = wr_ctrl && reg_wdata[B_FLUSHTX];
    assign flush_rx = wr_ctrl && reg_wdata[B_FLUSHRX];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.line_pol <= reg_wdata[B_LPOL +: NUM_CS];
                ctrl_q.rd_en    <= reg_wdata[B_RDEN];
                ctrl_q.ie_fill  <= reg_wdata[B_IEFILL];
                ctrl_q.ie_done  <= reg_wdata[B_IEDONE];
                ctrl_q.run      <= reg_wdata[B_RUN];
                ctrl_q.gpol     <= reg_wdata[B_GPOL];
                ctrl_q.cpol     <= reg_wdata[B_CPOL];
                ctrl_q.cpha     <= reg_wdata[B_CPHA];
                ctrl_q.sel      <= reg_wdata[1:0];
            end
            if (wr_div)
                div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              sh_pop, sh_push, sh_busy;

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx),
        .push(wr_data), .wdata(reg_wdata[DATA_W-1:0]),
        .pop(sh_pop), .head(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx),
        .push(sh_push), .wdata(rx_byte),
        .pop(rd_data), .head(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    spim_shifter #(.BITS(DATA_W), .DIVW(DIV_W)) u_shift (
        .clk(clk), .rst(rst), .en(ctrl_q.run),
        .go(!tx_empty && !rx_full),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .div(div_q),
        .tx_byte(tx_head), .tx_pop(sh_pop),
        .miso(spi_miso), .rx_push(sh_push), .rx_byte(rx_byte),
        .busy(sh_busy), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    logic done, rx_hi;
    assign done  = ctrl_q.run && tx_empty && !sh_busy;
    assign rx_hi = (rx_count >= CW'(FILL_LEVEL));
    assign irq   = (done && ctrl_q.ie_done) || (rx_hi && ctrl_q.ie_fill);

    logic [NUM_CS-1:0] act_lvl;
    assign act_lvl = active_levels(ctrl_q);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        logic on;
        assign on        = ctrl_q.run && (ctrl_q.sel == 2'(i));
        assign spi_cs[i] = on ? act_lvl[i] : !act_lvl[i];
    end

    logic [REG_W-1:0] status_w;
    always_comb begin
        status_w                      = '0;
        status_w[1:0]                 = ctrl_q.sel;
        status_w[B_CPHA]              = ctrl_q.cpha;
        status_w[B_CPOL]              = ctrl_q.cpol;
        status_w[B_GPOL]              = ctrl_q.gpol;
        status_w[B_RUN]               = ctrl_q.run;
        status_w[B_IEDONE]            = ctrl_q.ie_done;
        status_w[B_IEFILL]            = ctrl_q.ie_fill;
        status_w[B_RDEN]              = ctrl_q.rd_en;
        status_w[B_DONE]              = done;
        status_w[B_RXAV]              = !rx_empty;
        status_w[B_TXSP]              = !tx_full;
        status_w[B_RXHI]              = rx_hi;
        status_w[B_RXFULL]            = rx_full;
        status_w[B_LPOL +: NUM_CS]    = ctrl_q.line_pol;
    end

    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = status_w;
            OFF_DATA: reg_rdata = {{(REG_W-DATA_W){1'b0}}, rx_head};
            OFF_DIV:  reg_rdata = {{(REG_W-DIV_W){1'b0}}, div_q};
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{reg_wdata[REG_W-1:B_LPOL+NUM_CS], reg_wdata[B_LPOL-1:B_RDEN+1],
                           reg_wdata[11], reg_wdata[8], tx_count};
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
    import spim_pkg::*;
#(
    parameter int CW = 5
) (
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl,
    input logic              busy,
    input logic              tx_pop,
    input logic              tx_empty,
    input logic              rx_push,
    input logic              rx_full,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs
);
    logic [NUM_CS-1:0] act;
    assign act = active_levels(ctrl);

    // R3
    tx_pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    // R9
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_sclk == ctrl.cpol));

    // R5
    run_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> !busy);

    // R6
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spi_cs ^ ~act));

    // R6
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run || ctrl.sel == 2'd3) |-> (spi_cs == ~act));
endmodule

bind spim_ctrl spim_ctrl_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .busy(sh_busy),
    .tx_pop(sh_pop), .tx_empty(tx_empty),
    .rx_push(sh_push), .rx_full(rx_full),
    .spi_sclk(spi_sclk), .spi_cs(spi_cs)
);

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, spi_sclk, spi_mosi, spi_miso;
    logic [2:0]  spi_cs;

    always #2 clk = ~clk;
    assign spi_miso = ~spi_mosi;

    spim_ctrl u_spim_ctrl (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // serial monitor: rebuilds bytes from spi_mosi on the sampling edge
    bit         mon_on = 0, cpol_tb = 0, cpha_tb = 0;
    logic [7:0] mon_sh = '0;
    logic [7:0] mon_q [16];
    int         mon_bits = 0, mon_n = 0;
    always @(spi_sclk) if (mon_on) begin
        if ((spi_sclk != cpol_tb) != cpha_tb) begin
            mon_sh = {mon_sh[6:0], spi_mosi};
            mon_bits++;
            if (mon_bits == 8) begin
                if (mon_n < 16) mon_q[mon_n] = mon_sh;
                mon_n++;
                mon_bits = 0;
            end
        end
    end

    // half-period measurement in system cycles
    logic prev_sclk = 1'b0;
    int   since = 0, gap = 0;
    always @(posedge clk) begin
        if (spi_sclk != prev_sclk) begin
            gap   <= since;
            since <= 1;
        end else begin
            since <= since + 1;
        end
        prev_sclk <= spi_sclk;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 0;
    endtask

    function automatic logic [31:0] cw(int sel, bit cpha, bit cpol, bit run,
                                       bit ie_done, bit ie_fill, bit flush,
                                       bit gpol, logic [2:0] lpol);
        logic [31:0] v = '0;
        v[1:0] = 2'(sel); v[2] = cpha; v[3] = cpol;
        v[4] = flush; v[5] = flush; v[6] = gpol; v[7] = run;
        v[9] = ie_done; v[10] = ie_fill; v[23:21] = lpol;
        return v;
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'(i * 37 + 5);
    endfunction

    task automatic wait_done(input string tag);
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            rd(4'h0, s);
            if (s[16]) return;
        end
        check({tag, " done timeout"}, 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); check("R1 status after reset", d, 32'h0004_0000);
        rd(4'h8, d); check("R1 divider after reset", d, 32'h0);
        check("R1 cs lines idle", {29'd0, spi_cs}, 32'd7);
        check("R1 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(4'h0, cw(2, 1, 1, 0, 1, 1, 1, 1, 3'b101) | 32'h1000);
        rd(4'h0, d); check("R2 control readback, flush bits 0", d, 32'h00A4_164E);
        check("R6 all lines active-high, idle low", {29'd0, spi_cs}, 32'd0);
        wr(4'h8, 32'hFFFF_1234);
        rd(4'h8, d); check("R2 divider readback", d, 32'h0000_1234);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_cs();
        wr(4'h0, cw(1, 0, 0, 0, 0, 0, 0, 0, 3'b010));
        check("R6 line1 active-high idle", {29'd0, spi_cs}, 32'b101);
        wr(4'h0, cw(1, 0, 0, 1, 0, 0, 0, 0, 3'b010));
        check("R6 line1 asserted high", {29'd0, spi_cs}, 32'b111);
        wr(4'h0, cw(3, 0, 0, 1, 0, 0, 0, 0, 3'b000));
        check("R6 select 3 none active", {29'd0, spi_cs}, 32'b111);
        wr(4'h0, cw(0, 0, 0, 1, 0, 0, 0, 1, 3'b000));
        check("R6 global polarity line0", {29'd0, spi_cs}, 32'b001);
        wr(4'h0, cw(2, 0, 0, 1, 0, 0, 0, 0, 3'b000));
        check("R6 line2 asserted low", {29'd0, spi_cs}, 32'b011);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_modes();
        logic [31:0] d;
        logic [7:0]  b [3];
        wr(4'h8, 32'd4);
        for (int m = 0; m < 4; m++) begin
            b[0] = 8'hA5; b[1] = 8'h3C; b[2] = 8'(8'h81 + m * 8'h11);
            cpha_tb = m[0]; cpol_tb = m[1];
            wr(4'h0, cw(m % 3, m[0], m[1], 0, 0, 0, 1, 0, 3'b000));
            mon_n = 0; mon_bits = 0; mon_on = 1;
            for (int i = 0; i < 3; i++) wr(4'h4, {24'd0, b[i]});
            wr(4'h0, cw(m % 3, m[0], m[1], 1, 0, 0, 0, 0, 3'b000));
            check($sformatf("R6 mode %0d select active low", m), {31'd0, spi_cs[m % 3]}, 32'd0);
            wait_done("R4");
            mon_on = 0;
            check($sformatf("R4 mode %0d byte count", m), mon_n, 32'd3);
            for (int i = 0; i < 3; i++) begin
                check($sformatf("R4 mode %0d mosi byte %0d", m, i), {24'd0, mon_q[i]}, {24'd0, b[i]});
                rd(4'h4, d);
                check($sformatf("R4 mode %0d rx byte %0d", m, i), d, {24'd0, ~b[i]});
            end
            check($sformatf("R5 mode %0d sclk idle", m), {31'd0, spi_sclk}, {31'd0, cpol_tb});
            check($sformatf("R5 mode %0d half period div4", m), gap, 32'd2);
            wr(4'h0, 32'h0);
        end
    endtask

    task automatic t_div();
        logic [31:0] d;
        int n;
        cpol_tb = 0; cpha_tb = 0;
        for (int k = 0; k < 2; k++) begin
            wr(4'h8, k == 0 ? 32'd6 : 32'd1);
            wr(4'h0, cw(0, 0, 0, 0, 0, 0, 1, 0, 3'b000));
            wr(4'h4, 32'h5A);
            wr(4'h0, cw(0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
            wait_done("R5");
            check($sformatf("R5 half period div %0d", k == 0 ? 6 : 1), gap, k == 0 ? 32'd3 : 32'd1);
        end
        wr(4'h8, 32'd0);
        wr(4'h0, cw(0, 0, 0, 0, 0, 0, 1, 0, 3'b000));
        wr(4'h4, 32'hC3);
        wr(4'h0, cw(0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
        n = 0;
        while (spi_sclk == 1'b0 && n < 40000) begin
            @(posedge clk); #1; n++;
        end
        check("R5 divider 0 first half period", {31'd0, (n >= 32768 && n <= 32770)}, 32'd1);
        wr(4'h0, cw(0, 0, 0, 0, 0, 0, 0, 0, 3'b000));
        repeat (2) @(negedge clk);
        check("R5 run cleared stops clock", {31'd0, spi_sclk}, 32'd0);
        wr(4'h0, cw(0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
        rd(4'h0, d);
        check("R5 aborted byte leaves idle", {30'd0, d[17], d[16]}, 32'b01);
        wr(4'h0, cw(0, 0, 0, 0, 0, 0, 1, 0, 3'b000));
    endtask

    task automatic t_done();
        logic [31:0] d;
        wr(4'h8, 32'd2);
        wr(4'h0, cw(0, 0, 0, 1, 1, 0, 1, 0, 3'b000));
        rd(4'h0, d); check("R7 done with empty queue", {31'd0, d[16]}, 32'd1);
        check("R11 irq on done", {31'd0, irq}, 32'd1);
        wr(4'h4, 32'h11);
        rd(4'h0, d); check("R7 done cleared by write", {31'd0, d[16]}, 32'd0);
        wait_done("R7");
        wr(4'h0, cw(0, 0, 0, 1, 0, 0, 1, 0, 3'b000));
        check("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        wr(4'h0, cw(0, 0, 0, 0, 0, 1, 1, 0, 3'b000));
        for (int i = 0; i < 12; i++) wr(4'h4, {24'd0, pat(i)});
        wr(4'h0, cw(0, 0, 0, 1, 0, 1, 0, 0, 3'b000));
        wait_done("R8");
        rd(4'h0, d);
        check("R8 flags at 12: full,high,avail", {29'd0, d[20], d[19], d[17]}, 32'b011);
        check("R11 irq on fill level", {31'd0, irq}, 32'd1);
        rd(4'h4, d); check("R12 oldest byte", d, {24'd0, ~pat(0)});
        rd(4'h0, d); check("R8 high clears at 11", {31'd0, d[19]}, 32'd0);
        check("R11 irq drops below level", {31'd0, irq}, 32'd0);
        wr(4'h0, cw(0, 0, 0, 0, 0, 0, 0, 0, 3'b000) | 32'h20);
        rd(4'h0, d); check("R10 receive flush", {30'd0, d[5], d[17]}, 32'd0);
    endtask

    task automatic t_stall();
        logic [31:0] d;
        wr(4'h0, cw(0, 0, 0, 0, 0, 0, 1, 0, 3'b000));
        for (int i = 0; i < 15; i++) wr(4'h4, {24'd0, pat(i)});
        rd(4'h0, d); check("R3 space at 15", {31'd0, d[18]}, 32'd1);
        wr(4'h4, {24'd0, pat(15)});
        rd(4'h0, d); check("R3 no space at 16", {31'd0, d[18]}, 32'd0);
        wr(4'h4, 32'hEE);
        wr(4'h0, cw(0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
        wait_done("R3");
        rd(4'h0, d); check("R8 full flag at 16", {31'd0, d[20]}, 32'd1);
        wr(4'h4, 32'h77);
        repeat (60) @(negedge clk);
        rd(4'h0, d); check("R9 stalled while full", {30'd0, d[16], d[20]}, 32'b01);
        rd(4'h4, d); check("R12 first byte", d, {24'd0, ~pat(0)});
        wait_done("R9");
        for (int i = 1; i < 16; i++) begin
            rd(4'h4, d);
            check($sformatf("R3 byte %0d, overflow dropped", i), d, {24'd0, ~pat(i)});
        end
        rd(4'h4, d); check("R9 resumed byte", d, 32'h0000_0088);
        rd(4'h4, d); check("R12 empty read is 0", d, 32'd0);
        rd(4'h0, d); check("R8 avail clear", {31'd0, d[17]}, 32'd0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        wr(4'h0, cw(0, 0, 0, 0, 0, 0, 1, 0, 3'b000));
        for (int i = 0; i < 5; i++) wr(4'h4, {24'd0, pat(i)});
        wr(4'h0, cw(0, 0, 0, 1, 0, 0, 0, 0, 3'b000) | 32'h10);
        rd(4'h0, d); check("R10 transmit flush gives done", {31'd0, d[16]}, 32'd1);
        repeat (40) @(negedge clk);
        rd(4'h0, d); check("R10 nothing shifted, flush reads 0", {29'd0, d[17], d[4], d[5]}, 32'd0);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_cs();
        t_modes();
        t_div();
        t_done();
        t_levels();
        t_stall();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule